// File: doc/BRIEF.md
# Palette and border colour stage

This block turns a 4-bit plane value, arriving once per pixel clock, into a 6-bit colour. The conversion goes through sixteen programmable palette entries. A per-plane enable mask is applied to the pixel value before the lookup. When the display is blanked, or when output is switched off, the block sends out a programmable border colour instead. It also exports a horizontal pan count and four mode bits, which downstream logic uses. Two diagnostic bits echo a selectable pair of colour lines.

The host programs the block through one 8-bit write port that plays two roles. An internal toggle decides whether each write is taken as a register index or as data for the register last indexed. The toggle flips on every write. A read of the status register, signalled by a one-cycle strobe, puts the toggle back to index. Each index write also sets the output-enable flag. Palette entries can only be changed while output is disabled.

Top module: `colour_lookup_ctrl`

## Requirements
- R1: After reset the block is as follows:
  - the port toggle expects an index and output is disabled;
  - all palette entries and the border colour are 0;
  - the plane mask is 4'hF;
  - the status selection, pan count and mode bits are 0.
  - So `pix_out` and `diag_bits` read 0.
- R2: Writes on the port alternate between two roles.
  - The first write after reset or after a status read is an index.
  - The write after it is data for the indexed register, and so on, flipping on every write.
- R3: A `stat_rd` strobe makes the next write an index. This holds even when the toggle was waiting for data. A write in the same cycle as the strobe is still handled in its own role.
- R4: In an index write, bits 4:0 choose the register. Bit 5 = 1 enables output; bit 5 = 0 disables it.
- R5: A data write to indices 0..15 does one of two things:
  - with output disabled, it stores bits 5:0 as that palette entry;
  - with output enabled, it is dropped and the entry keeps its value.
- R6: Data writes to indices 16..19 always take effect:
  - index 16 (10h): bits 3:0 go to `mode_bits`;
  - index 17 (11h): bits 5:0 become the border colour;
  - index 18 (12h): bits 3:0 are the plane mask and bits 5:4 the status selection;
  - index 19 (13h): bits 3:0 go to `pan_count`.
- R7: With output enabled and `blank` low, `pix_out` one clock later equals the palette entry at index (`pix_val` AND plane mask). The mask and palette used are the ones in force in the cycle the pixel was presented.
- R8: When `blank` is high or output is disabled, `pix_out` one clock later equals the border colour.
- R9: `diag_bits` is taken from the current `pix_out` word, whose bits are 0 blue, 1 green, 2 red, 3 second blue, 4 second green, 5 second red:

  | Status selection | `diag_bits[1]` | `diag_bits[0]` |
  |---|---|---|
  | 0 | bit 2 | bit 0 |
  | 1 | bit 1 | bit 3 |
  | 2 | bit 4 | bit 5 |
  | 3 | 0 | 0 |
- R10: Data writes to indices 20..31 change no register, but the toggle still flips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel and register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe for the shared port |
| wr_data | input | 8 | Host write byte (index or data) |
| stat_rd | input | 1 | Status register read strobe; returns the toggle to index |
| pix_val | input | 4 | Plane value of the current pixel |
| blank | input | 1 | Blanking interval; border colour is sent |
| pix_out | output | 6 | Registered output colour |
| diag_bits | output | 2 | Selected pair of colour lines from pix_out |
| pan_count | output | 4 | Horizontal pan count |
| mode_bits | output | 4 | Mode flags: graphics, mono, 9-dot, blink (bits 0..3) |

## Verification
The bench breaks an index/data pair with a status read. If the toggle were not restored, the retried index would land as data in the pan register and the following write would be taken as an index. The bench writes to palette entries while output is on; a design that failed to lock them would show the new colour on the next matching pixel. It writes data to an unused index and changes the plane mask between pixels, which catches a design that decodes only the low index bits or applies the mask late. It walks through every status selection, which exposes swapped or missing colour lines.

// File: rtl/colour_pkg.sv
package colour_pkg;
    parameter int CW   = 6;
    parameter int NPAL = 16;
    parameter int IW   = 5;
    parameter int DW   = 8;
    localparam int PW  = $clog2(NPAL);

    localparam logic [IW-1:0] A_MODE   = 5'h10;
    localparam logic [IW-1:0] A_BORDER = 5'h11;
    localparam logic [IW-1:0] A_PLANES = 5'h12;
    localparam logic [IW-1:0] A_PAN    = 5'h13;

    typedef logic [NPAL-1:0][CW-1:0] pal_t;

    typedef struct packed {
        logic          phase;   // 0: next write is index, 1: data
        logic [IW-1:0] idx;
        logic          out_en;
    } port_t;

    typedef struct packed {
        pal_t          pal;
        logic [CW-1:0] border;
        logic [PW-1:0] mask;
        logic [1:0]    sel;
        logic [3:0]    pan;
        logic [3:0]    mode;
    } regs_t;

    typedef struct packed {
        logic [CW-1:0] pix;
    } pipe_t;
endpackage

// File: rtl/host_port_seq.sv
module host_port_seq
    import colour_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          stat_rd,
    output logic          reg_we,
    output logic [IW-1:0] reg_addr,
    output logic          out_en
);
    port_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            if (!s_q.phase) begin
                s_d.idx    = wr_data[IW-1:0];
                s_d.out_en = wr_data[IW];
            end
            s_d.phase = ~s_q.phase;
        end
        if (stat_rd) s_d.phase = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign reg_we   = wr_en && s_q.phase;
    assign reg_addr = s_q.idx;
    assign out_en   = s_q.out_en;

    assert_status_read_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> !s_q.phase);
    assert_toggle_flips_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !stat_rd) |=> (s_q.phase != $past(s_q.phase)));
endmodule

// File: rtl/colour_regfile.sv
module colour_regfile
    import colour_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          lock,
    output pal_t          pal,
    output logic [CW-1:0] border,
    output logic [PW-1:0] mask,
    output logic [1:0]    sel,
    output logic [3:0]    pan,
    output logic [3:0]    mode
);
    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we) begin
            for (int i = 0; i < NPAL; i++) begin
                if (addr == IW'(i) && !lock) r_d.pal[i] = wdata[CW-1:0];
            end
            case (addr)
                A_MODE:   r_d.mode   = wdata[3:0];
                A_BORDER: r_d.border = wdata[CW-1:0];
                A_PLANES: begin
                    r_d.mask = wdata[PW-1:0];
                    r_d.sel  = wdata[5:4];
                end
                A_PAN:    r_d.pan    = wdata[3:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.mask <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign pal    = r_q.pal;
    assign border = r_q.border;
    assign mask   = r_q.mask;
    assign sel    = r_q.sel;
    assign pan    = r_q.pan;
    assign mode   = r_q.mode;

    assert_palette_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr < IW'(NPAL) && lock) |=> $stable(r_q.pal));
    assert_unused_index_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr > A_PAN) |=> $stable(r_q));
endmodule

// File: rtl/colour_pipe.sv
module colour_pipe
    import colour_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  pal_t          pal,
    input  logic [CW-1:0] border,
    input  logic [PW-1:0] mask,
    input  logic [1:0]    sel,
    input  logic          out_en,
    input  logic [PW-1:0] pix_val,
    input  logic          blank,
    output logic [CW-1:0] pix_out,
    output logic [1:0]    diag
);
    pipe_t p_d, p_q;
    logic [1:0] taps [4];

    always_comb begin
        p_d = p_q;
        if (blank || !out_en) p_d.pix = border;
        else                  p_d.pix = pal[pix_val & mask];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    // Status selection table: pairs of colour bits {bit for diag[1], bit for diag[0]}
    localparam int HI_BIT [3] = '{2, 1, 4};
    localparam int LO_BIT [3] = '{0, 3, 5};

    for (genvar g = 0; g < 3; g++) begin : g_tap
        assign taps[g] = {p_q.pix[HI_BIT[g]], p_q.pix[LO_BIT[g]]};
    end
    assign taps[3] = 2'b00;

    assign pix_out = p_q.pix;
    assign diag    = taps[sel];

    assert_border_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (blank || !out_en) |=> (pix_out == $past(border)));
    assert_lookup_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!blank && out_en) |=> (pix_out == $past(pal[pix_val & mask])));
endmodule

// File: rtl/colour_lookup_ctrl.sv
module colour_lookup_ctrl
    import colour_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          stat_rd,
    input  logic [3:0]    pix_val,
    input  logic          blank,
    output logic [5:0]    pix_out,
    output logic [1:0]    diag_bits,
    output logic [3:0]    pan_count,
    output logic [3:0]    mode_bits
);
    logic          reg_we;
    logic [IW-1:0] reg_addr;
    logic          out_en;
    pal_t          pal;
    logic [CW-1:0] border;
    logic [PW-1:0] mask;
    logic [1:0]    sel;

    host_port_seq u_port (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .stat_rd(stat_rd), .reg_we(reg_we), .reg_addr(reg_addr), .out_en(out_en)
    );

    colour_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(wr_data),
        .lock(out_en), .pal(pal), .border(border), .mask(mask), .sel(sel),
        .pan(pan_count), .mode(mode_bits)
    );

    colour_pipe u_pipe (
        .clk(clk), .rst_n(rst_n), .pal(pal), .border(border), .mask(mask),
        .sel(sel), .out_en(out_en), .pix_val(pix_val), .blank(blank),
        .pix_out(pix_out), .diag(diag_bits)
    );

    assert_reset_output_R1: assert property (@(posedge clk)
        !rst_n |=> (pix_out == '0 && pan_count == '0 && mode_bits == '0));
endmodule

// File: tb/colour_lookup_ctrl_tb_top.sv
module colour_lookup_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       stat_rd = 1'b0;
    logic [3:0] pix_val = '0;
    logic       blank = 1'b0;
    logic [5:0] pix_out;
    logic [1:0] diag_bits;
    logic [3:0] pan_count;
    logic [3:0] mode_bits;

    int n_tests = 0;
    int n_fail  = 0;

    // reference model state
    int m_phase, m_idx, m_oe, m_border, m_mask, m_sel, m_pan, m_mode, e_pix;
    int m_pal [16];

    always #10 clk = ~clk;

    colour_lookup_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .stat_rd(stat_rd), .pix_val(pix_val), .blank(blank),
        .pix_out(pix_out), .diag_bits(diag_bits),
        .pan_count(pan_count), .mode_bits(mode_bits)
    );

    function automatic int exp_diag(int c, int s);
        case (s)
            0: return (((c >> 2) & 1) << 1) | (c & 1);
            1: return (((c >> 1) & 1) << 1) | ((c >> 3) & 1);
            2: return (((c >> 4) & 1) << 1) | ((c >> 5) & 1);
            default: return 0;
        endcase
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_phase = 0; m_idx = 0; m_oe = 0; m_border = 0; m_mask = 15;
        m_sel = 0; m_pan = 0; m_mode = 0; e_pix = 0;
        for (int i = 0; i < 16; i++) m_pal[i] = 0;
    endtask

    task automatic model_clock(bit we, int d, bit rd, int px, bit bl);
        if (bl || m_oe == 0) e_pix = m_border;
        else                 e_pix = m_pal[px & m_mask];
        if (we) begin
            if (m_phase == 0) begin
                m_idx = d & 31;
                m_oe  = (d >> 5) & 1;
            end else begin
                if (m_idx < 16) begin
                    if (m_oe == 0) m_pal[m_idx] = d & 63;
                end else if (m_idx == 16) m_mode = d & 15;
                else if (m_idx == 17) m_border = d & 63;
                else if (m_idx == 18) begin
                    m_mask = d & 15;
                    m_sel  = (d >> 4) & 3;
                end else if (m_idx == 19) m_pan = d & 15;
            end
            m_phase = 1 - m_phase;
        end
        if (rd) m_phase = 0;
    endtask

    task automatic step(string tag, bit we, int d, bit rd, int px, bit bl);
        wr_en = we; wr_data = d[7:0]; stat_rd = rd; pix_val = px[3:0]; blank = bl;
        @(posedge clk);
        model_clock(we, d, rd, px, bl);
        @(negedge clk);
        wr_en = 1'b0; stat_rd = 1'b0;
        check(tag, "pix_out", int'(pix_out), e_pix);
        check(tag, "diag_bits", int'(diag_bits), exp_diag(e_pix, m_sel));
        check(tag, "pan_count", int'(pan_count), m_pan);
        check(tag, "mode_bits", int'(mode_bits), m_mode);
    endtask

    task automatic wr(string tag, int d);
        step(tag, 1'b1, d, 1'b0, 0, 1'b0);
    endtask

    task automatic pix(string tag, int px, bit bl);
        step(tag, 1'b0, 0, 1'b0, px, bl);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state visible at the ports
        check("R1", "pix_out", int'(pix_out), 0);
        check("R1", "diag_bits", int'(diag_bits), 0);
        check("R1", "pan_count", int'(pan_count), 0);
        check("R1", "mode_bits", int'(mode_bits), 0);
        pix("R1", 5, 1'b0);

        // R2 R4 R5: program palette with output disabled (index bit5 = 0)
        for (int i = 0; i < 16; i++) begin
            wr("R2", i);
            wr("R5", (i * 7 + 3) & 63);
        end
        // R8: output still disabled -> border (0)
        pix("R8", 9, 1'b0);
        // R6: border colour, then R4 enable output via index bit5 with plane register
        wr("R6", 8'h11); wr("R6", 8'h2A);
        pix("R8", 4, 1'b0);
        wr("R4", 8'h32); wr("R6", 8'h0F);
        // R7: lookup with full mask
        for (int i = 0; i < 16; i++) pix("R7", i, 1'b0);
        // R8: blanking gives border
        pix("R8", 6, 1'b1);
        pix("R8", 6, 1'b1);
        // R7: plane mask 0101 changed between pixels
        wr("R6", 8'h32); wr("R7", 8'h05);
        for (int i = 0; i < 16; i++) pix("R7", i, 1'b0);
        // R5: palette write while output enabled is dropped
        wr("R5", 8'h23); wr("R5", 8'h3F);
        wr("R6", 8'h32); wr("R6", 8'h0F);
        pix("R5", 3, 1'b0);
        // R3: status read breaks an index/data pair
        wr("R3", 8'h33);
        step("R3", 1'b0, 0, 1'b1, 2, 1'b0);
        wr("R3", 8'h33); wr("R3", 8'h07);
        // R3: status read in the same cycle as a data write
        wr("R3", 8'h33);
        step("R3", 1'b1, 8'h09, 1'b1, 1, 1'b0);
        wr("R3", 8'h30); wr("R6", 8'h0B);
        // R10: unused index data write changes nothing, toggle still flips
        wr("R10", 8'h35); wr("R10", 8'h3F);
        wr("R10", 8'h3E); wr("R10", 8'h12);
        pix("R10", 7, 1'b0);
        // R9: all status selections
        for (int s = 0; s < 4; s++) begin
            wr("R9", 8'h32); wr("R9", (s << 4) | 15);
            for (int i = 0; i < 16; i++) pix("R9", i, 1'b0);
            pix("R9", 0, 1'b1);
        end
        // R4: index write with bit5 clear disables output -> border
        wr("R4", 8'h13); wr("R4", 8'h02);
        pix("R4", 5, 1'b0);
        // R5: palette now writable again
        wr("R5", 8'h05); wr("R5", 8'h15);
        wr("R5", 8'h25); wr("R5", 8'h00);
        pix("R5", 5, 1'b0);
        pix("R5", 5, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule